// File: doc/BRIEF.md
# Processor Control-Pin Interrupt Front End

This block sits between the external control pins of a processor core and the core's pending-interrupt logic. Each pin change reaches it as an event: a valid strobe, a pin index and the new level. The block compares the new level with the last level it recorded for that pin. It acts only when the two differ.

Each pin has its own sensitivity and polarity:

- Interrupt-style pins set or clear bits in a pending mask.
- The checkstop pin halts the core.
- The hard-reset pin raises a one-cycle system reset request.
- The time-base enable pin runs or freezes the time base.

A combined hard-interrupt request is high while any pending bit is set. The machine-check bit is sticky, so software clears it through a dedicated acknowledge input.

Top module: `ipc_pin_ctrl`

## Requirements
- R1: An event whose level equals the recorded level for that pin produces no effect on any pending bit, halt, reset request or time-base enable.
- R2: Pin index 1 (external interrupt) drives pending bit 0, and pin index 2 (system management interrupt) drives pending bit 1. Both are active high: the bit takes the new level one cycle after a changing event.
- R3: Pin index 3 (machine check) sets pending bit 2 one cycle after a 1-to-0 change of that pin. A rising change leaves the bit unchanged.
- R4: Pending bit 2 stays set until `mck_ack` is high for a cycle. When a falling machine-check change and the acknowledge arrive in the same cycle, the bit ends set.
- R5: A change of pin index 4 (checkstop, active low) to level 0 sets `halted` one cycle later. `halted` then stays high, whatever that pin does, until reset.
- R6: A change of pin index 5 (hard reset, active low) to level 0 raises `sys_reset_req` for exactly one cycle, one cycle later. A change to 1 raises nothing.
- R7: Pin index 6 (soft reset) drives pending bit 3, following the pin level, one cycle after a changing event.
- R8: Pin index 0 (time-base enable) sets `tb_run` to the new level one cycle after a changing event.
- R9: `hard_req` is high exactly when the pending mask is nonzero.
- R10: Every valid event stores its level in bit `evt_pin` of `pin_state` one cycle later. This includes index 7, which is unassigned and otherwise causes no action.
- R11: After reset, `pin_state`, `pending`, `hard_req`, `halted`, `sys_reset_req` and `tb_run` are all zero. An active-low pin therefore needs a high event before a low event counts as an assertion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_valid | input | 1 | A pin event is presented this cycle |
| evt_pin | input | 3 | Index of the pin the event refers to |
| evt_level | input | 1 | New level of that pin |
| mck_ack | input | 1 | Clears the sticky machine-check pending bit |
| pin_state | output | 8 | Last recorded level of each pin |
| pending | output | 4 | Pending mask: external, system management, machine check, soft reset |
| hard_req | output | 1 | Combined interrupt request |
| halted | output | 1 | Core is stopped by checkstop |
| sys_reset_req | output | 1 | One-cycle system reset request |
| tb_run | output | 1 | Time base runs while high |

## Verification
A wrong recorded level in `pin_state` is visible at the port in the next cycle. It also changes which later event counts as an edge: a machine-check bit set by a repeated low, or a halt that never comes, shows up one cycle after the following event on that pin. A corrupted pending bit shows in `pending` and `hard_req` in the same cycle it is stored. The bench's behavioural model is compared with every output on every clock, so any divergence is reported in the cycle it first appears.

// File: rtl/ipc_pkg.sv
package ipc_pkg;
  // pin indices, decoded by the event front end
  localparam int PIN_TBEN  = 0;
  localparam int PIN_INT   = 1;
  localparam int PIN_SMI   = 2;
  localparam int PIN_MCP   = 3;
  localparam int PIN_CKSTP = 4;
  localparam int PIN_HRST  = 5;
  localparam int PIN_SRST  = 6;

  // pending mask bit positions
  localparam int PB_EXT = 0;
  localparam int PB_SMI = 1;
  localparam int PB_MCK = 2;
  localparam int PB_RST = 3;
  localparam int NPEND  = 4;

  typedef struct packed {
    logic tb_wr;
    logic tb_val;
    logic ckstp_on;
    logic hrst_on;
  } ctl_evt_t;
endpackage

// File: rtl/ipc_pin_decode.sv
module ipc_pin_decode
  import ipc_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   evt_valid,
  input  logic [IDX_W-1:0]       evt_pin,
  input  logic                   evt_level,
  output logic [(1<<IDX_W)-1:0]  pin_state,
  output logic [NPEND-1:0]       pend_wr,
  output logic [NPEND-1:0]       pend_val,
  output ctl_evt_t               ctl
);
  localparam int NPINS = 1 << IDX_W;
  localparam logic [IDX_W-1:0] I_TBEN  = IDX_W'(PIN_TBEN);
  localparam logic [IDX_W-1:0] I_INT   = IDX_W'(PIN_INT);
  localparam logic [IDX_W-1:0] I_SMI   = IDX_W'(PIN_SMI);
  localparam logic [IDX_W-1:0] I_MCP   = IDX_W'(PIN_MCP);
  localparam logic [IDX_W-1:0] I_CKSTP = IDX_W'(PIN_CKSTP);
  localparam logic [IDX_W-1:0] I_HRST  = IDX_W'(PIN_HRST);
  localparam logic [IDX_W-1:0] I_SRST  = IDX_W'(PIN_SRST);

  logic             prev;
  logic             chg;
  logic [NPINS-1:0] state_nxt;

  always_comb begin
    prev = pin_state[evt_pin];
    chg  = evt_valid && (prev != evt_level);

    state_nxt = pin_state;
    state_nxt[evt_pin] = evt_level;

    pend_wr  = '0;
    pend_val = '0;
    ctl      = '0;

    if (chg) begin
      unique case (evt_pin)
        I_TBEN: begin
          ctl.tb_wr  = 1'b1;
          ctl.tb_val = evt_level;
        end
        I_INT: begin
          pend_wr[PB_EXT]  = 1'b1;
          pend_val[PB_EXT] = evt_level;
        end
        I_SMI: begin
          pend_wr[PB_SMI]  = 1'b1;
          pend_val[PB_SMI] = evt_level;
        end
        I_MCP: begin
          pend_wr[PB_MCK]  = prev && !evt_level;
          pend_val[PB_MCK] = 1'b1;
        end
        I_CKSTP: ctl.ckstp_on = !evt_level;
        I_HRST:  ctl.hrst_on  = !evt_level;
        I_SRST: begin
          pend_wr[PB_RST]  = 1'b1;
          pend_val[PB_RST] = evt_level;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_state <= '0;
    end else if (evt_valid) begin
      pin_state <= state_nxt;
    end
  end

  // R10: the addressed bit records the level of every valid event
  a_r10_level_recorded: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |=> pin_state[$past(evt_pin)] == $past(evt_level));
endmodule

// File: rtl/ipc_pend_regs.sv
module ipc_pend_regs
  import ipc_pkg::*;
#(
  parameter int               N      = NPEND,
  parameter logic [NPEND-1:0] STICKY = NPEND'(1) << PB_MCK
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] wr,
  input  logic [N-1:0] val,
  input  logic         ack,
  output logic [N-1:0] q
);
  logic [N-1:0] nxt;

  for (genvar i = 0; i < N; i++) begin : g_bit
    if (STICKY[i]) begin : g_sticky
      // set beats clear so a fresh event is never lost
      always_comb nxt[i] = (q[i] && !ack) || (wr[i] && val[i]);

      // R4: acknowledge without a simultaneous set leaves the bit clear
      a_r4_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        ack && !wr[i] |=> !q[i]);
      // R4: a set arriving with acknowledge wins
      a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        wr[i] && val[i] |=> q[i]);
    end else begin : g_level
      always_comb nxt[i] = wr[i] ? val[i] : q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else begin
      q <= nxt;
    end
  end
endmodule

// File: rtl/ipc_core_ctl.sv
module ipc_core_ctl
  import ipc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  ctl_evt_t ctl,
  output logic     tb_run,
  output logic     halted,
  output logic     sys_reset_req
);
  logic tb_nxt;
  logic halt_nxt;

  always_comb begin
    tb_nxt   = ctl.tb_wr ? ctl.tb_val : tb_run;
    halt_nxt = halted || ctl.ckstp_on;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tb_run        <= 1'b0;
      halted        <= 1'b0;
      sys_reset_req <= 1'b0;
    end else begin
      tb_run        <= tb_nxt;
      halted        <= halt_nxt;
      sys_reset_req <= ctl.hrst_on;
    end
  end

  // R5: once halted, only reset restarts the core
  a_r5_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);
  // R6: reset request is a single-cycle pulse
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    sys_reset_req |=> !sys_reset_req);
  // R8: time-base enable holds when no time-base event arrives
  a_r8_tb_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.tb_wr |=> $stable(tb_run));
endmodule

// File: rtl/ipc_pin_ctrl.sv
module ipc_pin_ctrl
  import ipc_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  evt_valid,
  input  logic [IDX_W-1:0]      evt_pin,
  input  logic                  evt_level,
  input  logic                  mck_ack,
  output logic [(1<<IDX_W)-1:0] pin_state,
  output logic [NPEND-1:0]      pending,
  output logic                  hard_req,
  output logic                  halted,
  output logic                  sys_reset_req,
  output logic                  tb_run
);
  logic [1:0]       rst_sync;
  logic             rst_q;
  logic [NPEND-1:0] pend_wr;
  logic [NPEND-1:0] pend_val;
  ctl_evt_t         ctl;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync <= 2'b00;
    end else begin
      rst_sync <= {rst_sync[0], 1'b1};
    end
  end
  assign rst_q = rst_sync[1];

  ipc_pin_decode #(.IDX_W(IDX_W)) u_dec (
    .clk       (clk),
    .rst_n     (rst_q),
    .evt_valid (evt_valid),
    .evt_pin   (evt_pin),
    .evt_level (evt_level),
    .pin_state (pin_state),
    .pend_wr   (pend_wr),
    .pend_val  (pend_val),
    .ctl       (ctl)
  );

  ipc_pend_regs #(.N(NPEND)) u_pend (
    .clk   (clk),
    .rst_n (rst_q),
    .wr    (pend_wr),
    .val   (pend_val),
    .ack   (mck_ack),
    .q     (pending)
  );

  ipc_core_ctl u_ctl (
    .clk           (clk),
    .rst_n         (rst_q),
    .ctl           (ctl),
    .tb_run        (tb_run),
    .halted        (halted),
    .sys_reset_req (sys_reset_req)
  );

  assign hard_req = |pending;

  // R1: an event repeating the recorded level changes nothing
  a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_q)
    evt_valid && (evt_level == pin_state[evt_pin]) && !mck_ack
    |=> $stable(pending) && $stable(tb_run) && !sys_reset_req);
  // R2: external interrupt bit follows a changing level
  a_r2_ext_follows: assert property (@(posedge clk) disable iff (!rst_q)
    evt_valid && evt_pin == IDX_W'(PIN_INT) |=> pending[PB_EXT] == $past(evt_level));
  // R3: a rising machine-check change does not set the bit
  a_r3_no_rise_set: assert property (@(posedge clk) disable iff (!rst_q)
    evt_valid && evt_pin == IDX_W'(PIN_MCP) && evt_level && !pending[PB_MCK]
    |=> !pending[PB_MCK]);
  // R10: the unassigned index leaves the pending mask alone
  a_r10_unknown_inert: assert property (@(posedge clk) disable iff (!rst_q)
    evt_valid && evt_pin == IDX_W'(7) && !mck_ack |=> $stable(pending));
endmodule

// File: tb/tb_ipc_pin_ctrl.sv
`timescale 1ns/1ps
module tb_ipc_pin_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       evt_valid = 1'b0;
  logic [2:0] evt_pin = '0;
  logic       evt_level = 1'b0;
  logic       mck_ack = 1'b0;
  logic [7:0] pin_state;
  logic [3:0] pending;
  logic       hard_req, halted, sys_reset_req, tb_run;

  always #2 clk = ~clk;

  ipc_pin_ctrl dut (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_pin(evt_pin),
    .evt_level(evt_level), .mck_ack(mck_ack), .pin_state(pin_state),
    .pending(pending), .hard_req(hard_req), .halted(halted),
    .sys_reset_req(sys_reset_req), .tb_run(tb_run)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // behavioural reference
  bit m_pin [8];
  bit m_ext, m_smi, m_mck, m_rst, m_halt, m_sreq, m_tb;

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_pin[k]) m_pin[k] = 0;
      m_ext = 0; m_smi = 0; m_mck = 0; m_rst = 0;
      m_halt = 0; m_sreq = 0; m_tb = 0;
    end else begin
      m_sreq = 0;
      if (mck_ack) m_mck = 0;
      if (evt_valid && m_pin[evt_pin] != evt_level) begin
        case (evt_pin)
          3'd0: m_tb = evt_level;
          3'd1: m_ext = evt_level;
          3'd2: m_smi = evt_level;
          3'd3: if (!evt_level) m_mck = 1;
          3'd4: if (!evt_level) m_halt = 1;
          3'd5: if (!evt_level) m_sreq = 1;
          3'd6: m_rst = evt_level;
          default: ;
        endcase
      end
      if (evt_valid) m_pin[evt_pin] = evt_level;
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int mpins();
    int v = 0;
    for (int k = 0; k < 8; k++) v |= int'(m_pin[k]) << k;
    return v;
  endfunction

  always @(negedge clk) begin
    if (!done) begin
      chk("R2 ext bit", pending[0], m_ext);
      chk("R2 smi bit", pending[1], m_smi);
      chk("R3/R4 mck bit", pending[2], m_mck);
      chk("R7 soft reset bit", pending[3], m_rst);
      chk("R9 hard_req", hard_req, int'(m_ext | m_smi | m_mck | m_rst));
      chk("R5 halted", halted, m_halt);
      chk("R6 sys_reset_req", sys_reset_req, m_sreq);
      chk("R8 tb_run", tb_run, m_tb);
      chk("R10/R1 pin_state", pin_state, mpins());
    end
  end

  task automatic ev(int pin, bit lvl, bit ack = 0);
    @(negedge clk); #1;
    evt_valid = 1; evt_pin = 3'(pin); evt_level = lvl; mck_ack = ack;
    @(negedge clk); #1;
    evt_valid = 0; mck_ack = 0;
  endtask

  task automatic ack_only();
    @(negedge clk); #1; mck_ack = 1;
    @(negedge clk); #1; mck_ack = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); #1; rst_n = 0;
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
    repeat (4) @(negedge clk);
    // R11 reset state
    chk("R11 reset pending", pending, 0);
    chk("R11 reset pin_state", pin_state, 0);
    chk("R11 reset halted", halted, 0);

    // R1/R11: active-low pins low from reset are not assertions
    ev(4, 0);
    chk("R1 checkstop no change", halted, 0);
    ev(5, 0);
    chk("R1 hard reset no change", sys_reset_req, 0);

    // R2 level following, repeated level
    ev(1, 1); ev(1, 1); ev(1, 0);
    ev(2, 1); ev(1, 1); ev(2, 0); ev(1, 0);
    // R7 and R8
    ev(6, 1); ev(6, 1); ev(6, 0);
    ev(0, 1);
    chk("R8 tb_run high", tb_run, 1);
    ev(0, 1); ev(0, 0);

    // R3: rise then fall, then R4 acknowledge
    ev(3, 1);
    chk("R3 rise ignored", pending[2], 0);
    ev(3, 0);
    chk("R3 fall sets", pending[2], 1);
    ev(3, 0);
    ev(1, 1); ev(1, 0);
    chk("R4 sticky", pending[2], 1);
    ack_only();
    chk("R4 ack clears", pending[2], 0);
    // R4 fall coincident with ack
    ev(3, 1); ev(3, 0, 1);
    chk("R4 set wins", pending[2], 1);
    ack_only();

    // R10 unknown pin
    ev(7, 1);
    chk("R10 unknown recorded", pin_state[7], 1);
    chk("R10 unknown inert", pending, 0);
    ev(7, 0);

    // R6 hard reset pulse
    ev(5, 1);
    ev(5, 0);
    // R5 checkstop
    ev(4, 1); ev(4, 0);
    chk("R5 halted", halted, 1);
    ev(4, 1);
    chk("R5 stays halted", halted, 1);

    do_reset();
    chk("R5 reset restarts", halted, 0);

    for (int n = 0; n < 600; n++) begin
      int p = int'($urandom_range(0, 7));
      bit l = bit'($urandom_range(0, 1));
      bit a = ($urandom_range(0, 7) == 0);
      ev(p, l, a);
    end
    ack_only();
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule